// File: doc/BRIEF.md
# Code Memory Lock Protection Unit

This block turns the state of three non-volatile lock bits into the gating signals that protect on-chip code memory. Each bit is either unprogrammed (read as 0) or programmed (read as 1). The bits map to one of four cumulative protection tiers, numbered 0 to 3. Every tier keeps all the restrictions of the tiers below it. The outputs are:

- a block on table-read instructions that run from external memory and try to read internal code;
- an inhibit on further programming;
- an inhibit on read-back (verify);
- an inhibit on executing code from external memory.

Once any protection is active, the unit samples the external-access pin on every reset cycle and holds that level after reset is released. It raises a mismatch flag whenever the held level differs from the live pin. The bits themselves are stored elsewhere; this unit only reads them. It re-evaluates its inputs on every clock and drives all of its results from registers.

Top module: `lock_protect_unit`

## Requirements
- R1: On the clock edge after a cycle in which `rst` is high, `tbl_block`, `prog_inh`, `verify_inh` and `xexec_inh` are all 1 (fail-safe) and `ea_mismatch` is 0.
- R2: The protection tier is the index of the highest programmed bit plus one, where bit 0 is the first lock bit. With all bits 0 the tier is 0, and every inhibit output and `ea_mismatch` is 0.
- R3: `prog_inh` is 1 exactly when the tier is 1 or higher.
- R4: `tbl_block` is 1 exactly when the tier is 1 or higher and `fetch_ext` (1 = the current fetch comes from external memory) is 1.
- R5: `verify_inh` is 1 exactly when the tier is 2 or higher.
- R6: `xexec_inh` is 1 exactly when the tier is 3.
- R7: Bit patterns outside the cumulative set take the tier of their highest programmed bit. For example, 3'b010 gives tier 2, and 3'b100, 3'b101 and 3'b110 give tier 3.
- R8: Each output reflects the inputs sampled at the previous rising clock edge. A change on an input does not reach any output before the next edge.
- R9: On each clock edge where `rst` is 1 and the tier is 1 or higher, `ea_latched` takes the level of `ext_pin`. On a reset edge at tier 0, it keeps its value.
- R10: While `rst` is 0, `ea_latched` does not change, whatever `ext_pin` and the lock bits do.
- R11: Outside reset, `ea_mismatch` is 1 exactly when, at the previous edge, the tier was 1 or higher and `ea_latched` differed from `ext_pin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_bits | input | 3 | Lock bit states, 1 = programmed, bit 0 first |
| ext_pin | input | 1 | Live level of the external-access pin |
| fetch_ext | input | 1 | 1 when the current fetch comes from external memory |
| tbl_block | output | 1 | Blocks table reads of internal code from external code |
| prog_inh | output | 1 | Inhibits programming |
| verify_inh | output | 1 | Inhibits verify read-back |
| xexec_inh | output | 1 | Inhibits external code execution |
| ea_latched | output | 1 | External-access level captured during reset |
| ea_mismatch | output | 1 | Captured and live external-access levels disagree |

## Verification
Every result, including the four gates, the captured pin level and the mismatch flag, is due exactly one rising edge after the inputs that cause it. The bench changes inputs on falling edges and reads outputs on the following falling edge, so each read falls half a period after the one edge that may update them. One step reads the outputs a nanosecond after an input change, before any edge, to confirm the old values are still held. The sweep covers all eight bit patterns with both fetch sources. Reset is entered at several tiers and pin levels to exercise capture, hold and mismatch.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef struct packed {
    logic tbl_block;
    logic prog_inh;
    logic verify_inh;
    logic xexec_inh;
  } gate_t;

  localparam gate_t GATES_SAFE = '{tbl_block: 1'b1, prog_inh: 1'b1,
                                   verify_inh: 1'b1, xexec_inh: 1'b1};
endpackage

// File: rtl/lock_tier_decode.sv
module lock_tier_decode #(
  parameter int LOCK_W = 3,
  localparam int TW = $clog2(LOCK_W + 1)
) (
  input  logic [LOCK_W-1:0] lock_bits,
  output logic [TW-1:0]     tier
);
  // highest programmed bit sets the tier; lower bits are implied
  always_comb begin
    tier = '0;
    for (int i = 0; i < LOCK_W; i++) begin
      if (lock_bits[i]) tier = TW'(i + 1);
    end
  end
endmodule

// File: rtl/lock_gate_regs.sv
module lock_gate_regs
  import lock_pkg::*;
#(
  parameter int LOCK_W      = 3,
  parameter int PROG_TIER   = 1,
  parameter int VERIFY_TIER = 2,
  parameter int XEXEC_TIER  = 3,
  localparam int TW = $clog2(LOCK_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tier,
  input  logic          fetch_ext,
  output gate_t         gates
);
  localparam logic [TW-1:0] T_PROG   = TW'(PROG_TIER);
  localparam logic [TW-1:0] T_VERIFY = TW'(VERIFY_TIER);
  localparam logic [TW-1:0] T_XEXEC  = TW'(XEXEC_TIER);

  always_ff @(posedge clk) begin
    if (rst) begin
      gates <= GATES_SAFE;
    end else begin
      gates.tbl_block  <= (tier >= T_PROG) && fetch_ext;
      gates.prog_inh   <= (tier >= T_PROG);
      gates.verify_inh <= (tier >= T_VERIFY);
      gates.xexec_inh  <= (tier >= T_XEXEC);
    end
  end
endmodule

// File: rtl/ea_sample_latch.sv
module ea_sample_latch (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ext_pin,
  output logic ea_latched,
  output logic ea_mismatch
);
  logic ea_q;
  logic mis_q;

  // no reset value: contents are arbitrary until a protected reset
  always_ff @(posedge clk) begin
    if (rst && active) ea_q <= ext_pin;
  end

  always_ff @(posedge clk) begin
    if (rst) mis_q <= 1'b0;
    else     mis_q <= active && (ea_q != ext_pin);
  end

  assign ea_latched  = ea_q;
  assign ea_mismatch = mis_q;
endmodule

// File: rtl/lock_protect_unit.sv
module lock_protect_unit
  import lock_pkg::*;
#(
  parameter int LOCK_W = 3,
  localparam int TW = $clog2(LOCK_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LOCK_W-1:0] lock_bits,
  input  logic              ext_pin,
  input  logic              fetch_ext,
  output logic              tbl_block,
  output logic              prog_inh,
  output logic              verify_inh,
  output logic              xexec_inh,
  output logic              ea_latched,
  output logic              ea_mismatch
);
  logic [TW-1:0] tier;
  gate_t         gates;
  logic          active;

  lock_tier_decode #(.LOCK_W(LOCK_W)) u_decode (
    .lock_bits(lock_bits),
    .tier     (tier)
  );

  lock_gate_regs #(
    .LOCK_W     (LOCK_W),
    .PROG_TIER  (1),
    .VERIFY_TIER(2),
    .XEXEC_TIER (LOCK_W)
  ) u_gates (
    .clk      (clk),
    .rst      (rst),
    .tier     (tier),
    .fetch_ext(fetch_ext),
    .gates    (gates)
  );

  assign active = (tier != '0);

  ea_sample_latch u_ea (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .ext_pin    (ext_pin),
    .ea_latched (ea_latched),
    .ea_mismatch(ea_mismatch)
  );

  assign tbl_block  = gates.tbl_block;
  assign prog_inh   = gates.prog_inh;
  assign verify_inh = gates.verify_inh;
  assign xexec_inh  = gates.xexec_inh;
endmodule

// File: rtl/lock_protect_chk.sv
module lock_protect_chk #(
  parameter int LOCK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [LOCK_W-1:0] lock_bits,
  input logic              ext_pin,
  input logic              fetch_ext,
  input logic              tbl_block,
  input logic              prog_inh,
  input logic              verify_inh,
  input logic              xexec_inh,
  input logic              ea_latched,
  input logic              ea_mismatch
);
  p_reset_safe_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tbl_block && prog_inh && verify_inh && xexec_inh && !ea_mismatch));

  p_prog_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (prog_inh == $past(|lock_bits)));

  p_table_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tbl_block == ($past(|lock_bits) && $past(fetch_ext))));

  p_verify_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (verify_inh == $past(|lock_bits[LOCK_W-1:1])));

  p_xexec_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (xexec_inh == $past(lock_bits[LOCK_W-1])));

  p_ea_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(ea_latched));

  p_mismatch_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ea_mismatch ==
      ($past(|lock_bits) && ($past(ea_latched) != $past(ext_pin)))));
endmodule

bind lock_protect_unit lock_protect_chk #(.LOCK_W(LOCK_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lock_bits  (lock_bits),
  .ext_pin    (ext_pin),
  .fetch_ext  (fetch_ext),
  .tbl_block  (tbl_block),
  .prog_inh   (prog_inh),
  .verify_inh (verify_inh),
  .xexec_inh  (xexec_inh),
  .ea_latched (ea_latched),
  .ea_mismatch(ea_mismatch)
);

// File: tb/lock_protect_unit_bench.sv
`timescale 1ns/1ps
module lock_protect_unit_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] lock_bits;
  logic       ext_pin;
  logic       fetch_ext;
  logic       tbl_block, prog_inh, verify_inh, xexec_inh, ea_latched, ea_mismatch;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lock_protect_unit u_lock_protect_unit (
    .clk(clk), .rst(rst), .lock_bits(lock_bits), .ext_pin(ext_pin),
    .fetch_ext(fetch_ext), .tbl_block(tbl_block), .prog_inh(prog_inh),
    .verify_inh(verify_inh), .xexec_inh(xexec_inh),
    .ea_latched(ea_latched), .ea_mismatch(ea_mismatch)
  );

  function automatic int tier_of(input int lk);
    int t = 0;
    for (int i = 0; i < 3; i++) if ((lk >> i) & 1) t = i + 1;
    return t;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; lock_bits = 3'b000; ext_pin = 1'b0; fetch_ext = 1'b0;
    step();
    // R1 reset fail-safe
    chk("R1 tbl_block", tbl_block, 1'b1);
    chk("R1 prog_inh", prog_inh, 1'b1);
    chk("R1 verify_inh", verify_inh, 1'b1);
    chk("R1 xexec_inh", xexec_inh, 1'b1);
    chk("R1 ea_mismatch", ea_mismatch, 1'b0);

    // R9 capture at tier 1
    lock_bits = 3'b001; ext_pin = 1'b1;
    step();
    chk("R9 capture high", ea_latched, 1'b1);

    // leave reset at tier 0 with pin low
    rst = 1'b0; lock_bits = 3'b000; ext_pin = 1'b0;
    step();
    chk("R2 tier0 prog_inh", prog_inh, 1'b0);
    chk("R2 tier0 xexec_inh", xexec_inh, 1'b0);
    chk("R2 tier0 ea_mismatch", ea_mismatch, 1'b0);
    chk("R10 hold after release", ea_latched, 1'b1);

    // full sweep of bit patterns and fetch source, pin matches latch
    ext_pin = 1'b1;
    for (int lk = 0; lk < 8; lk++) begin
      for (int f = 0; f < 2; f++) begin
        int t;
        lock_bits = 3'(lk); fetch_ext = 1'(f);
        t = tier_of(lk);
        step();
        chk("R3 prog_inh", prog_inh, t >= 1);
        chk("R4 tbl_block", tbl_block, (t >= 1) && (f == 1));
        chk("R5 verify_inh", verify_inh, t >= 2);
        chk("R6 xexec_inh", xexec_inh, t >= 3);
        if (lk == 2 || lk >= 4) chk("R7 odd pattern verify", verify_inh, 1'b1);
        chk("R11 no mismatch when equal", ea_mismatch, 1'b0);
      end
    end

    // R8 registered timing
    lock_bits = 3'b000; fetch_ext = 1'b0;
    step();
    lock_bits = 3'b100;
    #1;
    chk("R8 old xexec before edge", xexec_inh, 1'b0);
    step();
    chk("R8 new xexec after edge", xexec_inh, 1'b1);

    // R10/R11 mismatch outside reset
    lock_bits = 3'b001; ext_pin = 1'b0;
    step();
    chk("R11 mismatch active", ea_mismatch, 1'b1);
    chk("R10 hold with pin low", ea_latched, 1'b1);
    lock_bits = 3'b000;
    step();
    chk("R11 no mismatch at tier0", ea_mismatch, 1'b0);

    // R9 hold on reset at tier 0
    rst = 1'b1; lock_bits = 3'b000; ext_pin = 1'b0;
    step();
    chk("R9 tier0 reset holds", ea_latched, 1'b1);

    // R7/R9 odd pattern 010 is protected and captures
    lock_bits = 3'b010;
    step();
    chk("R9 capture low via odd pattern", ea_latched, 1'b0);
    rst = 1'b0; ext_pin = 1'b1;
    step();
    chk("R7 odd pattern verify", verify_inh, 1'b1);
    chk("R7 odd pattern xexec", xexec_inh, 1'b0);
    chk("R11 mismatch after odd capture", ea_mismatch, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule